// File: doc/BRIEF.md
# SPI Global Control Register and Loopback Switch

This block holds the global control word of an SPI controller and turns it into the static controls that the rest of the controller uses. Software reaches the word through a simple register port that has a privilege input. From the stored fields the block produces these outputs: an enable, a soft-clear level for the datapath, a power-down request, a master select and a clock-source select. It also produces output enables for the enable pin and the chip-select pins, and a flag for an illegal loopback setup.

The block also contains the self-test loopback switch. While loopback is set, the transmit data lanes feed the receive data lanes inside the block. The external serial clock pad is held at the idle level that the polarity input gives, and the external receive-data pad drivers are turned off. The shift engine, the clock divider, the buffers and the flags live elsewhere. They connect only through the clear level and the switch ports.

Top module: `spi_gctl`

## Requirements
- R1: After reset every stored field is 0, a read of the register returns 0, and `clr_o` is 1.
- R2: At address 0x04 the register holds enable in bit 24, loopback in bit 16, power-down in bit 8, clock mode in bit 1 and master in bit 0. All other bits read 0, and writes to them are ignored.
- R3: `rdata_o` shows the register one cycle after a read strobe. A write and a read in the same cycle return the value from before the write. A read at any other address returns 0, and a write there changes nothing.
- R4: The loopback bit changes only on a write with `priv_i`=1. A write without privilege leaves loopback as it was and still updates the other fields.
- R5: `clr_o` is 1 whenever the stored enable bit is 0, and 0 when the enable bit is 1.
- R6: With loopback=1, `rx_data_o` equals `tx_data_i`. With loopback=0, it equals `rx_pad_i`.
- R7: With loopback=1, `sclk_pad_o` equals `cpol_i` and every bit of `somi_oe_o` is 0. With loopback=0, both pass through from the core inputs.
- R8: `cfg_err_o` is 1 exactly when loopback=1 and either master=0 or clock mode=0.
- R9: With clock mode=0, `ena_oe_o`=1 and every bit of `cs_oe_o` is 0. With clock mode=1, `ena_oe_o`=0 and every bit of `cs_oe_o` is 1.
- R10: `en_o`, `pdn_o`, `master_o` and `clkint_o` show the stored enable, power-down, master and clock-mode bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | DATA_W | Write data |
| priv_i | input | 1 | Privileged access |
| rdata_o | output | DATA_W | Read data, one cycle after the strobe |
| en_o | output | 1 | Transfer enable |
| clr_o | output | 1 | Datapath soft clear |
| pdn_o | output | 1 | Power-down request |
| master_o | output | 1 | Master select |
| clkint_o | output | 1 | Internal clock select |
| cfg_err_o | output | 1 | Illegal loopback setup |
| ena_oe_o | output | 1 | Enable pin output enable |
| cs_oe_o | output | NCS | Chip-select pin output enables |
| tx_data_i | input | LANES | Transmit lanes from the engine |
| rx_pad_i | input | LANES | Receive lanes from the pads |
| rx_data_o | output | LANES | Receive lanes to the engine |
| sclk_core_i | input | 1 | Serial clock from the divider |
| cpol_i | input | 1 | Idle clock level |
| sclk_pad_o | output | 1 | Serial clock to the pad |
| somi_oe_core_i | input | LANES | Receive pad drive enables from the engine |
| somi_oe_o | output | LANES | Receive pad drive enables to the pads |

## Verification
The assertions check four things on every cycle. Loopback must stay unchanged after a write without privilege. Reserved read bits must stay zero, and a miss read must return zero. With loopback set, the pads must be quiet and the lanes must be switched. The pin directions must agree with clock mode, and the error flag may rise only while loopback is set. Some cases need ordered stimulus, and only the bench scenarios show them. These are the old value returned on a write and read in the same cycle, the fields that update beside a loopback write that is refused, and the clear level as enable turns on and then off again.

// File: rtl/spi_gctl_pkg.sv
package spi_gctl_pkg;
  localparam int unsigned GCTL_OFS = 4;
  localparam int unsigned B_EN     = 24;
  localparam int unsigned B_LOOP   = 16;
  localparam int unsigned B_PDN    = 8;
  localparam int unsigned B_CLKINT = 1;
  localparam int unsigned B_MASTER = 0;

  typedef struct packed {
    logic en;
    logic loop;
    logic pdn;
    logic clkint;
    logic master;
  } gctl_t;
endpackage

// File: rtl/spi_gctl_regs.sv
module spi_gctl_regs
  import spi_gctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              priv_i,
  output logic [DATA_W-1:0] rdata_o,
  output gctl_t             q_o
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(GCTL_OFS);
  localparam logic [DATA_W-1:0] FMASK = (DATA_W'(1) << B_EN) | (DATA_W'(1) << B_LOOP) |
                                        (DATA_W'(1) << B_PDN) | (DATA_W'(1) << B_CLKINT) |
                                        (DATA_W'(1) << B_MASTER);

  gctl_t q;
  logic hit;
  logic [DATA_W-1:0] view;

  assign hit = (addr_i == OFS);

  always_comb begin
    view = '0;
    view[B_EN]     = q.en;
    view[B_LOOP]   = q.loop;
    view[B_PDN]    = q.pdn;
    view[B_CLKINT] = q.clkint;
    view[B_MASTER] = q.master;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (wr_i && hit) begin
      q.en     <= wdata_i[B_EN];
      q.pdn    <= wdata_i[B_PDN];
      q.clkint <= wdata_i[B_CLKINT];
      q.master <= wdata_i[B_MASTER];
      if (priv_i) q.loop <= wdata_i[B_LOOP];
    end
  end

  // read returns pre-write value on a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= hit ? view : '0;
    else           rdata_o <= '0;
  end

  assign q_o = q;

  // R4
  loop_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit && !priv_i) |=> $stable(q.loop));
  // R2
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~FMASK) == '0);
  // R3
  miss_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !hit) |=> rdata_o == '0);
endmodule

// File: rtl/spi_gctl_ctrl.sv
module spi_gctl_ctrl #(
  parameter int unsigned NCS = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           loop_i,
  input  logic           master_i,
  input  logic           clkint_i,
  output logic           clr_o,
  output logic           cfg_err_o,
  output logic           ena_oe_o,
  output logic [NCS-1:0] cs_oe_o
);
  assign clr_o     = ~en_i;
  assign cfg_err_o = loop_i & ~(master_i & clkint_i);
  // internal clock: enable pin is an input, chip selects drive
  assign ena_oe_o  = ~clkint_i;

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_oe_o[i] = clkint_i;
  end

  // R8
  err_needs_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> loop_i);
  // R9
  pin_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ena_oe_o |-> (cs_oe_o == '0));
endmodule

// File: rtl/spi_gctl_loop.sv
module spi_gctl_loop #(
  parameter int unsigned LANES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             loop_i,
  input  logic [LANES-1:0] tx_i,
  input  logic [LANES-1:0] rx_pad_i,
  input  logic             sclk_core_i,
  input  logic             cpol_i,
  input  logic [LANES-1:0] somi_oe_core_i,
  output logic [LANES-1:0] rx_o,
  output logic             sclk_pad_o,
  output logic [LANES-1:0] somi_oe_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rx_o[i]      = loop_i ? tx_i[i] : rx_pad_i[i];
    assign somi_oe_o[i] = somi_oe_core_i[i] & ~loop_i;
  end

  assign sclk_pad_o = loop_i ? cpol_i : sclk_core_i;

  // R7
  pads_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_i |-> (somi_oe_o == '0 && sclk_pad_o == cpol_i));
  // R6
  lane_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_i |-> (rx_o == tx_i));
endmodule

// File: rtl/spi_gctl.sv
module spi_gctl
  import spi_gctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 8,
  parameter int unsigned NCS    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              priv_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic              clr_o,
  output logic              pdn_o,
  output logic              master_o,
  output logic              clkint_o,
  output logic              cfg_err_o,
  output logic              ena_oe_o,
  output logic [NCS-1:0]    cs_oe_o,
  input  logic [LANES-1:0]  tx_data_i,
  input  logic [LANES-1:0]  rx_pad_i,
  output logic [LANES-1:0]  rx_data_o,
  input  logic              sclk_core_i,
  input  logic              cpol_i,
  output logic              sclk_pad_o,
  input  logic [LANES-1:0]  somi_oe_core_i,
  output logic [LANES-1:0]  somi_oe_o
);
  gctl_t q;

  spi_gctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .priv_i,
    .rdata_o, .q_o(q)
  );

  spi_gctl_ctrl #(.NCS(NCS)) u_ctrl (
    .clk_i, .rst_ni,
    .en_i(q.en), .loop_i(q.loop), .master_i(q.master), .clkint_i(q.clkint),
    .clr_o, .cfg_err_o, .ena_oe_o, .cs_oe_o
  );

  spi_gctl_loop #(.LANES(LANES)) u_loop (
    .clk_i, .rst_ni, .loop_i(q.loop),
    .tx_i(tx_data_i), .rx_pad_i, .sclk_core_i, .cpol_i, .somi_oe_core_i,
    .rx_o(rx_data_o), .sclk_pad_o, .somi_oe_o
  );

  assign en_o     = q.en;
  assign pdn_o    = q.pdn;
  assign master_o = q.master;
  assign clkint_o = q.clkint;

  // R5
  clr_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o != en_o);
endmodule

// File: tb/sim_spi_gctl.sv
module sim_spi_gctl;
  localparam int ADDR_W = 8, DATA_W = 32, LANES = 8, NCS = 6;

  logic clk = 0, rst_ni = 0;
  logic [ADDR_W-1:0] addr = 8'h04;
  logic wr = 0, rd = 0, priv = 0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic en, clr, pdn, master, clkint, cfg_err, ena_oe;
  logic [NCS-1:0] cs_oe;
  logic [LANES-1:0] tx = 8'hA5, rxp = 8'h3C, rxd, oe_core = 8'hFF, oe;
  logic sclk_core = 1, cpol = 0, sclk_pad;

  always #4 clk = ~clk;

  spi_gctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .NCS(NCS)) u0 (
    .clk_i(clk), .rst_ni, .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .priv_i(priv), .rdata_o(rdata), .en_o(en), .clr_o(clr), .pdn_o(pdn),
    .master_o(master), .clkint_o(clkint), .cfg_err_o(cfg_err), .ena_oe_o(ena_oe),
    .cs_oe_o(cs_oe), .tx_data_i(tx), .rx_pad_i(rxp), .rx_data_o(rxd),
    .sclk_core_i(sclk_core), .cpol_i(cpol), .sclk_pad_o(sclk_pad),
    .somi_oe_core_i(oe_core), .somi_oe_o(oe)
  );

  int checks = 0, errors = 0;
  logic [DATA_W-1:0] exp_q[$];
  string tag_q[$];
  logic pend = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compare read data one cycle after each strobe
  always @(posedge clk) pend <= rd & rst_ni;
  always @(negedge clk) if (pend) begin
    if (exp_q.size() == 0) chk("R3 unexpected read", 32'h0, 32'h1);
    else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  task automatic access(logic [7:0] a, logic w, logic r, logic [31:0] d, logic p,
                        logic [31:0] exp, string tag);
    @(negedge clk);
    addr = a; wr = w; rd = r; wdata = d; priv = p;
    if (r) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(negedge clk);
    wr = 0; rd = 0; addr = 8'h04;
  endtask

  task automatic rd_reg(logic [31:0] exp, string tag);
    access(8'h04, 0, 1, '0, 0, exp, tag);
  endtask

  task automatic wr_reg(logic [31:0] d, logic p);
    access(8'h04, 1, 0, d, p, '0, "");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 en", en, 0);
    chk("R1 R5 clr after reset", clr, 1);
    rd_reg(32'h0, "R1 reset read");

    // non-privileged all-ones write
    wr_reg(32'hFFFF_FFFF, 0);
    rd_reg(32'h0100_0103, "R2 R4 reserved and loop masked");
    chk("R5 clr with enable", clr, 0);
    chk("R10 fields", {en, pdn, master, clkint}, 4'hF);
    chk("R9 clkint dirs", {ena_oe, cs_oe}, {1'b0, {NCS{1'b1}}});
    chk("R8 no loop", cfg_err, 0);
    chk("R6 no loop lanes", rxd, rxp);
    chk("R7 no loop pads", {sclk_pad, oe}, {sclk_core, oe_core});

    // privileged loopback
    wr_reg(32'h0101_0003, 1);
    rd_reg(32'h0101_0003, "R4 privileged loop write");
    chk("R6 loop lanes", rxd, tx);
    tx = 8'h5E; #1;
    chk("R6 loop lanes 2", rxd, 8'h5E);
    chk("R7 somi off", oe, 0);
    chk("R7 sclk idle low", sclk_pad, 0);
    cpol = 1; sclk_core = 0; #1;
    chk("R7 sclk idle high", sclk_pad, 1);
    chk("R8 legal loop", cfg_err, 0);
    chk("R10 pdn off", pdn, 0);

    // unprivileged clear attempt; other fields update
    wr_reg(32'h0000_0001, 0);
    rd_reg(32'h0001_0001, "R4 loop kept, others updated");
    chk("R8 loop with external clock", cfg_err, 1);
    chk("R9 external dirs", {ena_oe, cs_oe}, {1'b1, {NCS{1'b0}}});
    chk("R5 clr after disable", clr, 1);

    // master off too
    wr_reg(32'h0000_0002, 0);
    chk("R8 loop as slave", cfg_err, 1);

    // same-cycle write and read
    access(8'h04, 1, 1, 32'h0100_0103, 0, 32'h0001_0002, "R3 old value on write+read");
    rd_reg(32'h0101_0103, "R3 new value after");

    // leave loopback
    wr_reg(32'h0100_0103, 1);
    rd_reg(32'h0100_0103, "R4 privileged clear");
    chk("R6 lanes back", rxd, rxp);
    chk("R7 pads back", {sclk_pad, oe}, {1'b0, oe_core});

    // other address
    access(8'h08, 1, 0, 32'h0, 1, '0, "");
    access(8'h08, 0, 1, '0, 0, 32'h0, "R3 miss read zero");
    rd_reg(32'h0100_0103, "R3 miss write ignored");

    wr_reg(32'h0100_0003, 0);
    chk("R10 pdn cleared", pdn, 0);
    chk("R10 en kept", en, 1);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) chk("R3 pending reads", 32'(exp_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule